// File: doc/BRIEF.md
# Set-Associative Address Translation Buffer with Access-Rights Check

This block maps a 32-bit virtual address to a 32-bit physical address. In the same lookup it decides whether the current access is allowed. Entries live in a set-associative array. Bits 16 to 12 of the virtual address pick the set. Every way of that set is then compared in parallel. Each entry carries its own page size, 1 kbyte or 4 kbyte. It also carries an address-space tag, a shared flag, a two-bit access key, a cacheable flag and a written-to flag.

Software fills entries through a dedicated write port. That port names the set, the way and every field, so the block picks no victim of its own. A lookup strobe starts a translation. The result appears on registered outputs one clock later: hit, miss, multiple match, physical address, cacheable, rights violation and first write to a clean page. In any cycle without a response, every result output is zero.

There are two synchronous active-low resets. The power-on reset invalidates every entry and clears the result registers. The manual reset clears only the result registers and keeps the stored entries.

Top module: `xlat_tlb`

## Requirements
- R1: The set is selected by VA[16:12]. These bits are never stored or compared, so an entry written to set s can only hit for lookups whose VA[16:12] equals s.
- R2: An entry with size bit 0 (1 kbyte page) hits only when VA[31:17] and VA[11:10] both equal its stored tag. The physical address is then {PPN[21:0], VA[9:0]}.
- R3: An entry with size bit 1 (4 kbyte page) compares only VA[31:17]. The physical address is then {PPN[21:2], VA[11:0]}, so PPN[1:0] and the stored tag bits [11:10] have no effect.
- R4: An entry with shared flag 0 hits only when its stored ASID equals the lookup ASID. An entry with shared flag 1 ignores the ASID.
- R5: The access key is encoded as follows: 00 allows privileged read only, 01 allows privileged read and write, 10 allows read only in both modes, and 11 allows read and write in both modes. On a hit, prot_viol is 1 for a user access to key 00 or 01, and for a write to key 00 or 10.
- R6: first_write is 1 when a write hits an entry whose dirty flag is 0 and raises no violation. The stored dirty flag is not changed, so the same access repeated flags again.
- R7: miss is 1 when no valid way matches. multi_hit is 1 together with hit when two or more valid ways match, and the result then comes from the lowest-numbered matching way.
- R8: Power-on reset invalidates all entries. Manual reset leaves all entries intact.
- R9: The results of a lookup strobed in cycle n appear in cycle n+1 with rsp_valid=1. An entry write in the same cycle as a lookup is not seen by that lookup, only by later ones.
- R10: On a hit, cacheable equals the entry's C flag. When rsp_valid is 0, or on a miss, pa, cacheable, prot_viol and first_write are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Manual reset, synchronous active-low, clears results only |
| por_rst_n | input | 1 | Power-on reset, synchronous active-low, also invalidates entries |
| lk_valid | input | 1 | Lookup strobe |
| lk_va | input | 32 | Virtual address |
| lk_asid | input | 8 | Current address-space ID |
| lk_user | input | 1 | 1 = user mode, 0 = privileged |
| lk_write | input | 1 | 1 = write access, 0 = read |
| wr_en | input | 1 | Entry write strobe |
| wr_set | input | 5 | Set index to write |
| wr_way | input | 2 | Way to write |
| wr_vpn_hi | input | 15 | Tag for VA[31:17] |
| wr_vpn_lo | input | 2 | Tag for VA[11:10] |
| wr_asid | input | 8 | Entry ASID |
| wr_shared | input | 1 | Shared flag |
| wr_big | input | 1 | Size bit, 1 = 4 kbyte page |
| wr_valid | input | 1 | Valid flag |
| wr_ppn | input | 22 | Physical page number, PA[31:10] |
| wr_key | input | 2 | Access key |
| wr_cache | input | 1 | Cacheable flag |
| wr_dirty | input | 1 | Written-to flag |
| rsp_valid | output | 1 | Result valid, one cycle after lk_valid |
| hit | output | 1 | A valid way matched |
| miss | output | 1 | No valid way matched |
| multi_hit | output | 1 | More than one way matched |
| pa | output | 32 | Physical address |
| cacheable | output | 1 | C flag of the hit entry |
| prot_viol | output | 1 | Access not allowed by the key |
| first_write | output | 1 | Permitted write to a clean page |

## Verification
Random lookups mostly reuse tags from entries already written. Those entries mix both page sizes, shared and private ASIDs, and all four keys, so hits dominate. They show whether the tag compare narrows correctly with page size and whether the address splice takes its low bits from the right source. Unrelated random addresses and wrong ASIDs produce misses, which separate the ASID bypass from a plain tag match. Directed cases cover the rest: the full key-by-mode-by-direction table, two ways holding the same tag, a write colliding with a lookup of the same set, and the two resets. Together they show rights decoding, lowest-way priority, read-before-write ordering, and which reset touches the valid bits.

// File: rtl/tlb_pkg.sv
// Package: shared field widths, entry layout and access-key codes for the
// translation buffer. Assumes 32-bit virtual and physical addresses, with
// the set index fixed at VA[16:12].
package tlb_pkg;
    localparam int VA_W    = 32;
    localparam int IDX_LO  = 12;
    localparam int IDX_W   = 5;
    localparam int NSETS   = 1 << IDX_W;
    localparam int HI_LO   = IDX_LO + IDX_W;      // 17
    localparam int HI_W    = VA_W - HI_LO;        // 15
    localparam int LO_W    = 2;                   // VA[11:10]
    localparam int OFS_W   = 10;
    localparam int PPN_W   = VA_W - OFS_W;        // 22
    localparam int ASID_W  = 8;

    typedef enum logic [1:0] {
        KEY_PRIV_RO = 2'b00,
        KEY_PRIV_RW = 2'b01,
        KEY_ALL_RO  = 2'b10,
        KEY_ALL_RW  = 2'b11
    } acc_key_e;

    typedef struct packed {
        logic [HI_W-1:0]   vpn_hi;
        logic [LO_W-1:0]   vpn_lo;
        logic [ASID_W-1:0] asid;
        logic              shared;
        logic              big;
        logic [PPN_W-1:0]  ppn;
        acc_key_e          key;
        logic              cache;
        logic              dirty;
    } tlb_entry_t;
endpackage

// File: rtl/tlb_entry_store.sv
// Entry storage: one array per way, indexed by set, read asynchronously at
// the lookup set. Assumes a single write port. Only the valid bits are reset,
// and only by the power-on reset. A write becomes visible after the clock edge.
module tlb_entry_store
    import tlb_pkg::*;
#(
    parameter int NUM_WAYS = 4,
    localparam int WAY_W   = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
    input  logic                 clk,
    input  logic                 por_rst_n,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_set,
    input  logic [WAY_W-1:0]     wr_way,
    input  tlb_entry_t           wr_entry,
    input  logic                 wr_valid,
    input  logic [IDX_W-1:0]     rd_set,
    output tlb_entry_t           rd_entry [NUM_WAYS],
    output logic [NUM_WAYS-1:0]  rd_valid
);
    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
        tlb_entry_t       mem [NSETS];
        logic [NSETS-1:0] vbits;
        logic             sel;

        assign sel = wr_en && (wr_way == WAY_W'(w));

        // Store entry fields for this way; no reset, since the fields are
        // qualified by the valid bits.
        always_ff @(posedge clk) begin
            if (sel) begin
                mem[wr_set] <= wr_entry;
            end
        end

        // Valid bits: cleared only by power-on reset.
        always_ff @(posedge clk) begin
            if (!por_rst_n) begin
                vbits <= '0;
            end else if (sel) begin
                vbits[wr_set] <= wr_valid;
            end
        end

        assign rd_entry[w] = mem[rd_set];
        assign rd_valid[w] = vbits[rd_set];
    end
endmodule

// File: rtl/tlb_way_match.sv
// Per-way compare: decides whether one entry matches the lookup address
// and ASID, and builds the physical address for that entry. Purely
// combinational. Assumes the set index bits were already used to read it.
module tlb_way_match
    import tlb_pkg::*;
(
    input  tlb_entry_t         entry,
    input  logic               valid,
    input  logic [VA_W-1:0]    va,
    input  logic [ASID_W-1:0]  asid,
    output logic               match,
    output logic [VA_W-1:0]    pa
);
    logic hi_eq, lo_eq, asid_ok;

    // Tag and ASID comparison, narrowed for large pages and shared entries.
    always_comb begin
        hi_eq   = (entry.vpn_hi == va[VA_W-1:HI_LO]);
        lo_eq   = entry.big || (entry.vpn_lo == va[OFS_W+LO_W-1:OFS_W]);
        asid_ok = entry.shared || (entry.asid == asid);
        match   = valid && hi_eq && lo_eq && asid_ok;
    end

    // Physical address splice; large pages take VA[11:10] from the input.
    always_comb begin
        if (entry.big) begin
            pa = {entry.ppn[PPN_W-1:LO_W], va[OFS_W+LO_W-1:0]};
        end else begin
            pa = {entry.ppn, va[OFS_W-1:0]};
        end
    end
endmodule

// File: rtl/tlb_prot_check.sv
// Access-rights decoder: bit 1 of the key grants user access and bit 0
// grants writes. Purely combinational.
module tlb_prot_check
    import tlb_pkg::*;
(
    input  acc_key_e key,
    input  logic     user,
    input  logic     write,
    output logic     viol
);
    logic user_ok, write_ok;

    // Decode the key into its two permissions and flag any denied access.
    always_comb begin
        user_ok  = (key == KEY_ALL_RO) || (key == KEY_ALL_RW);
        write_ok = (key == KEY_PRIV_RW) || (key == KEY_ALL_RW);
        viol     = (user && !user_ok) || (write && !write_ok);
    end
endmodule

// File: rtl/xlat_tlb.sv
// Top: set-associative translation buffer with access-rights check.
// Reads all ways of the set chosen by VA[16:12], matches in parallel, picks
// the lowest matching way, and registers the results one cycle after the
// strobe. Assumes the caller writes entries with an explicit set and way.
module xlat_tlb
    import tlb_pkg::*;
#(
    parameter int NUM_WAYS = 4,
    localparam int WAY_W   = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1,
    localparam int CNT_W   = $clog2(NUM_WAYS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                por_rst_n,
    input  logic                lk_valid,
    input  logic [31:0]         lk_va,
    input  logic [7:0]          lk_asid,
    input  logic                lk_user,
    input  logic                lk_write,
    input  logic                wr_en,
    input  logic [4:0]          wr_set,
    input  logic [WAY_W-1:0]    wr_way,
    input  logic [14:0]         wr_vpn_hi,
    input  logic [1:0]          wr_vpn_lo,
    input  logic [7:0]          wr_asid,
    input  logic                wr_shared,
    input  logic                wr_big,
    input  logic                wr_valid,
    input  logic [21:0]         wr_ppn,
    input  logic [1:0]          wr_key,
    input  logic                wr_cache,
    input  logic                wr_dirty,
    output logic                rsp_valid,
    output logic                hit,
    output logic                miss,
    output logic                multi_hit,
    output logic [31:0]         pa,
    output logic                cacheable,
    output logic                prot_viol,
    output logic                first_write
);
    tlb_entry_t             wr_entry;
    tlb_entry_t             rd_entry [NUM_WAYS];
    logic [NUM_WAYS-1:0]    rd_valid;
    logic [NUM_WAYS-1:0]    way_match;
    logic [VA_W-1:0]        way_pa [NUM_WAYS];
    logic [IDX_W-1:0]       rd_set;

    tlb_entry_t             sel_entry;
    logic [VA_W-1:0]        sel_pa;
    logic                   any_match;
    logic [CNT_W-1:0]       match_cnt;
    logic                   sel_viol;
    logic                   rst_any_n;

    // Pack the write-port fields into one entry word.
    always_comb begin
        wr_entry.vpn_hi = wr_vpn_hi;
        wr_entry.vpn_lo = wr_vpn_lo;
        wr_entry.asid   = wr_asid;
        wr_entry.shared = wr_shared;
        wr_entry.big    = wr_big;
        wr_entry.ppn    = wr_ppn;
        wr_entry.key    = acc_key_e'(wr_key);
        wr_entry.cache  = wr_cache;
        wr_entry.dirty  = wr_dirty;
    end

    assign rd_set    = lk_va[IDX_LO+IDX_W-1:IDX_LO];
    assign rst_any_n = rst_n && por_rst_n;

    tlb_entry_store #(.NUM_WAYS(NUM_WAYS)) u_store (
        .clk       (clk),
        .por_rst_n (por_rst_n),
        .wr_en     (wr_en),
        .wr_set    (wr_set),
        .wr_way    (wr_way),
        .wr_entry  (wr_entry),
        .wr_valid  (wr_valid),
        .rd_set    (rd_set),
        .rd_entry  (rd_entry),
        .rd_valid  (rd_valid)
    );

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_match
        tlb_way_match u_match (
            .entry (rd_entry[w]),
            .valid (rd_valid[w]),
            .va    (lk_va),
            .asid  (lk_asid),
            .match (way_match[w]),
            .pa    (way_pa[w])
        );
    end

    // Choose the lowest matching way and count how many ways matched.
    always_comb begin
        sel_entry = '0;
        sel_pa    = '0;
        any_match = 1'b0;
        match_cnt = '0;
        for (int w = NUM_WAYS - 1; w >= 0; w--) begin
            if (way_match[w]) begin
                sel_entry = rd_entry[w];
                sel_pa    = way_pa[w];
                any_match = 1'b1;
            end
        end
        for (int w = 0; w < NUM_WAYS; w++) begin
            match_cnt = match_cnt + CNT_W'(way_match[w]);
        end
    end

    tlb_prot_check u_prot (
        .key   (sel_entry.key),
        .user  (lk_user),
        .write (lk_write),
        .viol  (sel_viol)
    );

    // Register the lookup results; all zero outside a response.
    always_ff @(posedge clk) begin
        if (!rst_any_n) begin
            rsp_valid   <= 1'b0;
            hit         <= 1'b0;
            miss        <= 1'b0;
            multi_hit   <= 1'b0;
            pa          <= '0;
            cacheable   <= 1'b0;
            prot_viol   <= 1'b0;
            first_write <= 1'b0;
        end else begin
            rsp_valid   <= lk_valid;
            hit         <= lk_valid && any_match;
            miss        <= lk_valid && !any_match;
            multi_hit   <= lk_valid && (match_cnt > CNT_W'(1));
            pa          <= (lk_valid && any_match) ? sel_pa : '0;
            cacheable   <= lk_valid && any_match && sel_entry.cache;
            prot_viol   <= lk_valid && any_match && sel_viol;
            first_write <= lk_valid && any_match && lk_write && !sel_viol
                           && !sel_entry.dirty;
        end
    end
endmodule

// File: rtl/tlb_sva.sv
// Checker: port-level properties of the translation buffer, bound to the top.
module tlb_sva (
    input logic        clk,
    input logic        rst_n,
    input logic        por_rst_n,
    input logic        lk_valid,
    input logic [31:0] lk_va,
    input logic        lk_write,
    input logic        rsp_valid,
    input logic        hit,
    input logic        miss,
    input logic        multi_hit,
    input logic [31:0] pa,
    input logic        cacheable,
    input logic        prot_viol,
    input logic        first_write
);
    a_r9_rsp_after_strobe: assert property (@(posedge clk)
        disable iff (!rst_n || !por_rst_n) lk_valid |=> rsp_valid);

    a_r9_no_rsp_without_strobe: assert property (@(posedge clk)
        disable iff (!rst_n || !por_rst_n) !lk_valid |=> !rsp_valid);

    a_r7_hit_or_miss: assert property (@(posedge clk)
        disable iff (!rst_n || !por_rst_n) rsp_valid |-> (hit ^ miss));

    a_r7_multi_is_hit: assert property (@(posedge clk)
        disable iff (!rst_n || !por_rst_n) multi_hit |-> hit);

    a_r10_idle_quiet: assert property (@(posedge clk)
        disable iff (!rst_n || !por_rst_n)
        !hit |-> (pa == 32'd0) && !cacheable && !prot_viol && !first_write);

    a_r6_first_write_clean: assert property (@(posedge clk)
        disable iff (!rst_n || !por_rst_n)
        lk_valid && !lk_write |=> !first_write);

    a_r6_first_write_permitted: assert property (@(posedge clk)
        disable iff (!rst_n || !por_rst_n) first_write |-> !prot_viol);

    a_r2_offset_kept: assert property (@(posedge clk)
        disable iff (!rst_n || !por_rst_n)
        lk_valid |=> !hit || (pa[9:0] == $past(lk_va[9:0])));
endmodule

bind xlat_tlb tlb_sva u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .por_rst_n   (por_rst_n),
    .lk_valid    (lk_valid),
    .lk_va       (lk_va),
    .lk_write    (lk_write),
    .rsp_valid   (rsp_valid),
    .hit         (hit),
    .miss        (miss),
    .multi_hit   (multi_hit),
    .pa          (pa),
    .cacheable   (cacheable),
    .prot_viol   (prot_viol),
    .first_write (first_write)
);

// File: tb/tb_xlat_tlb.sv
// Bench: random and directed lookups checked against a bench-side model.
module tb_xlat_tlb;
    logic        clk = 1'b0;
    logic        rst_n, por_rst_n;
    logic        lk_valid, lk_user, lk_write;
    logic [31:0] lk_va;
    logic [7:0]  lk_asid;
    logic        wr_en, wr_shared, wr_big, wr_valid, wr_cache, wr_dirty;
    logic [4:0]  wr_set;
    logic [1:0]  wr_way, wr_vpn_lo, wr_key;
    logic [14:0] wr_vpn_hi;
    logic [7:0]  wr_asid;
    logic [21:0] wr_ppn;
    logic        rsp_valid, hit, miss, multi_hit, cacheable, prot_viol, first_write;
    logic [31:0] pa;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    xlat_tlb dut (.*);

    // Bench model of the stored entries.
    bit          m_v    [4][32];
    logic [14:0] m_hi   [4][32];
    logic [1:0]  m_lo   [4][32];
    logic [7:0]  m_asid [4][32];
    bit          m_sh   [4][32];
    bit          m_sz   [4][32];
    logic [21:0] m_ppn  [4][32];
    logic [1:0]  m_key  [4][32];
    bit          m_c    [4][32];
    bit          m_d    [4][32];

    // Expected {hit, miss, multi, cacheable, viol, first_write, pa}.
    function automatic logic [37:0] model(input logic [31:0] va, input logic [7:0] asid,
                                          input bit user, input bit wr);
        int s = int'(va[16:12]);
        int n = 0;
        int first = -1;
        logic [31:0] p = '0;
        bit v = 0;
        for (int w = 0; w < 4; w++) begin
            if (m_v[w][s] && m_hi[w][s] == va[31:17] && (m_sz[w][s] || m_lo[w][s] == va[11:10])
                && (m_sh[w][s] || m_asid[w][s] == asid)) begin
                n++;
                if (first < 0) first = w;
            end
        end
        if (first < 0) return {1'b0, 1'b1, 36'd0};
        p = m_sz[first][s] ? {m_ppn[first][s][21:2], va[11:0]} : {m_ppn[first][s], va[9:0]};
        v = (user && !m_key[first][s][1]) || (wr && !m_key[first][s][0]);
        return {1'b1, 1'b0, n > 1, m_c[first][s], v, wr && !v && !m_d[first][s], p};
    endfunction

    task automatic check(input string req, input logic [37:0] act, input logic [37:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive_write(input int s, input int w, input logic [14:0] hi, input logic [1:0] lo,
                               input logic [7:0] asid, input bit sh, input bit sz, input bit v,
                               input logic [21:0] ppn, input logic [1:0] key, input bit c, input bit d);
        wr_en = 1; wr_set = 5'(s); wr_way = 2'(w); wr_vpn_hi = hi; wr_vpn_lo = lo;
        wr_asid = asid; wr_shared = sh; wr_big = sz; wr_valid = v; wr_ppn = ppn;
        wr_key = key; wr_cache = c; wr_dirty = d;
    endtask

    task automatic model_write(input int s, input int w, input logic [14:0] hi, input logic [1:0] lo,
                               input logic [7:0] asid, input bit sh, input bit sz, input bit v,
                               input logic [21:0] ppn, input logic [1:0] key, input bit c, input bit d);
        m_v[w][s] = v; m_hi[w][s] = hi; m_lo[w][s] = lo; m_asid[w][s] = asid;
        m_sh[w][s] = sh; m_sz[w][s] = sz; m_ppn[w][s] = ppn; m_key[w][s] = key;
        m_c[w][s] = c; m_d[w][s] = d;
    endtask

    task automatic put(input int s, input int w, input logic [14:0] hi, input logic [1:0] lo,
                       input logic [7:0] asid, input bit sh, input bit sz, input bit v,
                       input logic [21:0] ppn, input logic [1:0] key, input bit c, input bit d);
        @(negedge clk);
        drive_write(s, w, hi, lo, asid, sh, sz, v, ppn, key, c, d);
        @(negedge clk);
        wr_en = 0;
        model_write(s, w, hi, lo, asid, sh, sz, v, ppn, key, c, d);
    endtask

    // Issue one lookup at a falling edge and check it one cycle later.
    task automatic look(input string req, input logic [31:0] va, input logic [7:0] asid,
                        input bit user, input bit wr);
        logic [37:0] exp;
        @(negedge clk);
        exp = model(va, asid, user, wr);
        lk_valid = 1; lk_va = va; lk_asid = asid; lk_user = user; lk_write = wr;
        @(negedge clk);
        lk_valid = 0;
        check(req, {hit, miss, multi_hit, cacheable, prot_viol, first_write, pa}, exp);
        if (rsp_valid !== 1'b1) begin
            checks++; fails++;
            $display("FAIL R9: rsp_valid actual %b expected 1", rsp_valid);
        end
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] va;
        void'($urandom(32'h1234_5678));
        rst_n = 0; por_rst_n = 0; lk_valid = 0; lk_va = 0; lk_asid = 0; lk_user = 0; lk_write = 0;
        drive_write(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        wr_en = 0;
        for (int w = 0; w < 4; w++) for (int s = 0; s < 32; s++) m_v[w][s] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1; por_rst_n = 1;
        @(negedge clk);
        // Reset state (R10): quiet outputs.
        check("R10 reset", {rsp_valid, hit, miss, multi_hit, cacheable, prot_viol, first_write, pa},
              39'd0);
        look("R8 empty after power-on", 32'h1234_5678, 8'h01, 0, 0);

        // R2: 1 kbyte page, exact tag bits 11:10 needed.
        put(5, 1, 15'h2AAA, 2'b10, 8'h11, 0, 0, 1, 22'h3F_0F0F, 2'b11, 1, 0);
        look("R2 1k hit", {15'h2AAA, 5'd5, 2'b10, 10'h155}, 8'h11, 0, 0);
        look("R2 1k wrong lo miss", {15'h2AAA, 5'd5, 2'b01, 10'h155}, 8'h11, 0, 0);
        // R1: same tag, other set.
        look("R1 other set miss", {15'h2AAA, 5'd6, 2'b10, 10'h155}, 8'h11, 0, 0);
        // R4: private ASID mismatch misses.
        look("R4 asid mismatch", {15'h2AAA, 5'd5, 2'b10, 10'h155}, 8'h12, 0, 0);
        // R3 and R4: 4 kbyte shared page, PPN[1:0]=11 must be ignored.
        put(9, 2, 15'h0101, 2'b00, 8'h40, 1, 1, 1, 22'h15_5557, 2'b10, 0, 1);
        look("R3 4k hit lo ignored", {15'h0101, 5'd9, 2'b11, 10'h2C3}, 8'h99, 0, 0);
        look("R4 shared any asid", {15'h0101, 5'd9, 2'b01, 10'h001}, 8'h00, 1, 0);

        // R5 and R6: full key, mode and direction table.
        for (int k = 0; k < 4; k++) begin
            put(20, 0, 15'h7000, 2'b00, 8'h05, 0, 1, 1, 22'h00_1000, 2'(k), k[0], 0);
            for (int m = 0; m < 4; m++)
                look("R5 key table", {15'h7000, 5'd20, 12'h0A4}, 8'h05, m[1], m[0]);
        end
        // R6: flag repeats since dirty is not updated.
        look("R6 first write again", {15'h7000, 5'd20, 12'h0A8}, 8'h05, 1, 1);
        put(20, 0, 15'h7000, 2'b00, 8'h05, 0, 1, 1, 22'h00_1000, 2'b11, 1, 1);
        look("R6 dirty page no flag", {15'h7000, 5'd20, 12'h0A8}, 8'h05, 1, 1);

        // R7: two ways with the same tag, lowest wins.
        put(3, 3, 15'h1111, 2'b01, 8'h07, 1, 0, 1, 22'h2B_BBBB, 2'b11, 1, 1);
        put(3, 1, 15'h1111, 2'b01, 8'h07, 1, 0, 1, 22'h0C_CCCC, 2'b10, 0, 1);
        look("R7 multi hit", {15'h1111, 5'd3, 2'b01, 10'h3FF}, 8'h07, 0, 0);

        // R9: write and lookup in the same cycle on the same set.
        @(negedge clk);
        va = {15'h4444, 5'd12, 2'b00, 10'h010};
        begin
            logic [37:0] exp;
            exp = model(va, 8'h03, 0, 0);
            lk_valid = 1; lk_va = va; lk_asid = 8'h03; lk_user = 0; lk_write = 0;
            drive_write(12, 2, 15'h4444, 2'b00, 8'h03, 0, 0, 1, 22'h11_2233, 2'b01, 1, 0);
            @(negedge clk);
            lk_valid = 0; wr_en = 0;
            model_write(12, 2, 15'h4444, 2'b00, 8'h03, 0, 0, 1, 22'h11_2233, 2'b01, 1, 0);
            check("R9 same-cycle write unseen", {hit, miss, multi_hit, cacheable, prot_viol,
                  first_write, pa}, exp);
        end
        look("R9 write seen later", va, 8'h03, 0, 0);

        // Random fill and lookups (R1 to R7, R10).
        for (int i = 0; i < 96; i++)
            put($urandom_range(31), $urandom_range(3), 15'($urandom), 2'($urandom), 8'($urandom % 4),
                bit'($urandom), bit'($urandom), ($urandom % 8) != 0, 22'($urandom), 2'($urandom),
                bit'($urandom), bit'($urandom));
        for (int i = 0; i < 600; i++) begin
            int s = $urandom_range(31);
            int w = $urandom_range(3);
            logic [7:0] a = (($urandom % 4) != 0) ? m_asid[w][s] : 8'($urandom % 4);
            if (($urandom % 5) == 0) va = $urandom;
            else va = {m_hi[w][s], 5'(s), (($urandom % 4) != 0) ? m_lo[w][s] : 2'($urandom),
                       10'($urandom)};
            look("R2/R3/R4/R5/R6/R7/R10 random", va, a, bit'($urandom), bit'($urandom));
        end

        // R8: manual reset keeps entries, power-on reset clears them.
        @(negedge clk); rst_n = 0;
        repeat (2) @(negedge clk); rst_n = 1;
        look("R8 kept after manual reset", {15'h4444, 5'd12, 2'b00, 10'h010}, 8'h03, 0, 0);
        @(negedge clk); por_rst_n = 0;
        repeat (2) @(negedge clk); por_rst_n = 1;
        for (int w = 0; w < 4; w++) for (int s = 0; s < 32; s++) m_v[w][s] = 0;
        look("R8 cleared by power-on", {15'h4444, 5'd12, 2'b00, 10'h010}, 8'h03, 0, 0);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule